// File: doc/BRIEF.md
# AAL5 PDU Framer and Checker

This block holds both ends of AAL5 adaptation for a byte-wide datapath. On the transmit side, a payload arrives as a valid/ready byte stream marked with start and end flags, together with a user-to-user byte and a common-part indicator byte. The block forwards the payload unchanged. It then appends as many zero bytes as are needed, followed by an 8-byte trailer, so that the whole PDU fills an exact number of 48-byte cells. The trailer holds the two side-band bytes, the 16-bit payload length and a CRC-32.

On the receive side, a reassembled PDU arrives as a byte stream with start and end flags. The block counts its bytes, pulls the length out of the trailer and compares the byte count with the padded size that length implies. It also checks the CRC. One cycle after the last byte, it reports the length along with two independent error flags.

Cell header generation, DMA and per-channel storage all sit outside this block.

Top module: `aal5_frame_unit`

## Requirements
- R1: After reset, with no input offered, `tx_out_valid` and `rx_done` are both low.
- R2: Payload bytes leave in arrival order and without change. `tx_out_sop` marks the first byte of each PDU and sits at cell position 0.
- R3: A PDU with an n-byte payload (1 to 65535 bytes) is exactly ceil((n+8)/48)*48 bytes long. `tx_out_eop` is set on its last byte only.
- R4: The pad lies between the payload and the trailer. Its count is the PDU size minus n minus 8, always in 0..47, and every pad byte is zero.
- R5: Trailer bytes 0 to 3, in output order, are UU, CPI, length[15:8] and length[7:0]. This forms a big-endian word with UU in bits 31:24, CPI in 23:16 and length in 15:0. The length is the number of payload bytes counted.
- R6: The last 4 bytes carry, most significant byte first, a CRC-32 over every earlier byte of the PDU. The CRC uses polynomial 0x04C11DB7, shifts each byte in MSB first, starts from all ones and is inverted at the end.
- R7: `tx_in_ready` stays low while pad or trailer bytes are being emitted.
- R8: One cycle after the byte flagged `rx_eop` is taken, `rx_done` pulses. `rx_len` then shows the low 16 bits of the second-to-last 32-bit word of the received PDU.
- R9: `rx_bad_len` is set when the received byte count differs from ceil((rx_len+8)/48)*48.
- R10: `rx_bad_crc` is set when the CRC over the received PDU, with its last 4 bytes taken as the check field, does not match. This flag does not depend on `rx_bad_len`.
- R11: While `tx_out_valid` is high and `tx_out_ready` is low, the output byte is held on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Payload byte offered |
| tx_in_ready | output | 1 | Payload byte taken |
| tx_in_data | input | 8 | Payload byte |
| tx_in_sop | input | 1 | First payload byte |
| tx_in_eop | input | 1 | Last payload byte |
| tx_uu | input | 8 | UU byte, sampled with the first byte |
| tx_cpi | input | 8 | CPI byte, sampled with the first byte |
| tx_out_valid | output | 1 | PDU byte offered |
| tx_out_ready | input | 1 | Downstream takes the PDU byte |
| tx_out_data | output | 8 | PDU byte |
| tx_out_sop | output | 1 | First PDU byte |
| tx_out_eop | output | 1 | Last PDU byte |
| rx_valid | input | 1 | Received byte present (always taken) |
| rx_data | input | 8 | Received byte |
| rx_sop | input | 1 | First byte of received PDU |
| rx_eop | input | 1 | Last byte of received PDU |
| rx_done | output | 1 | One-cycle result strobe |
| rx_len | output | 16 | Length field from the trailer |
| rx_bad_len | output | 1 | Byte count does not match the padded length |
| rx_bad_crc | output | 1 | CRC mismatch |

## Verification
The transmit path has no pipeline register. A payload byte appears on `tx_out_data` in the same cycle it is offered, and pad and trailer bytes follow on the cycles the downstream accepts them. The bench therefore drives inputs on the falling edge, samples the combinational outputs just after that, and records only the bytes that are handshaken.

The receive results are registered. They are due exactly one cycle after the end-of-PDU byte, so the bench reads them on the falling edge that follows the clock edge that took that byte. A stall pattern on `tx_out_ready` covers the hold rule and shows that pad and trailer timing do not depend on back-pressure.

// File: rtl/aal5_frame_unit.sv
module aal5_frame_unit #(
  parameter int CELL = 48,
  parameter int LW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [7:0]    tx_in_data,
  input  logic          tx_in_sop,
  input  logic          tx_in_eop,
  input  logic [7:0]    tx_uu,
  input  logic [7:0]    tx_cpi,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [7:0]    tx_out_data,
  output logic          tx_out_sop,
  output logic          tx_out_eop,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_sop,
  input  logic          rx_eop,
  output logic          rx_done,
  output logic [LW-1:0] rx_len,
  output logic          rx_bad_len,
  output logic          rx_bad_crc
);
  localparam int PW = $clog2(CELL);
  localparam int CW = LW + 1;
  localparam logic [PW-1:0] POS_PRE_TRL = PW'(CELL - 9);
  localparam logic [PW-1:0] POS_LAST    = PW'(CELL - 1);
  localparam logic [31:0] POLY    = 32'h04C11DB7;
  localparam logic [31:0] RESIDUE = 32'hC704DD7B;

  typedef enum logic [1:0] {S_PAY = 2'd0, S_PAD = 2'd1, S_TRL = 2'd2} st_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = (r << 1) ^ POLY;
      else              r = r << 1;
    end
    return r;
  endfunction

  st_t           st;
  logic [PW-1:0] pos;
  logic [LW-1:0] len_cnt;
  logic [2:0]    tidx;
  logic [31:0]   crc;
  logic [7:0]    uu_q, cpi_q;
  logic [7:0]    tbyte;
  logic [31:0]   crc_nxt;
  logic          fire;
  logic          in_pay;

  assign in_pay       = (st == S_PAY);
  assign tx_in_ready  = in_pay & tx_out_ready;
  assign tx_out_valid = in_pay ? tx_in_valid : 1'b1;
  assign tx_out_sop   = in_pay & tx_in_sop;
  assign tx_out_eop   = (st == S_TRL) && (tidx == 3'd7);
  assign fire         = tx_out_valid & tx_out_ready;

  always_comb begin
    case (tidx)
      3'd0:    tbyte = uu_q;
      3'd1:    tbyte = cpi_q;
      3'd2:    tbyte = len_cnt[15:8];
      3'd3:    tbyte = len_cnt[7:0];
      3'd4:    tbyte = ~crc[31:24];
      3'd5:    tbyte = ~crc[23:16];
      3'd6:    tbyte = ~crc[15:8];
      default: tbyte = ~crc[7:0];
    endcase
  end

  assign tx_out_data = in_pay ? tx_in_data : (st == S_PAD) ? 8'h00 : tbyte;
  assign crc_nxt     = crc_step((in_pay && tx_in_sop) ? 32'hFFFFFFFF : crc, tx_out_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_PAY;
      pos     <= '0;
      len_cnt <= '0;
      tidx    <= '0;
      crc     <= '1;
      uu_q    <= '0;
      cpi_q   <= '0;
    end else if (fire) begin
      pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
      case (st)
        S_PAY: begin
          crc     <= crc_nxt;
          len_cnt <= tx_in_sop ? LW'(1) : len_cnt + 1'b1;
          if (tx_in_sop) begin
            uu_q  <= tx_uu;
            cpi_q <= tx_cpi;
          end
          if (tx_in_eop) begin
            tidx <= '0;
            st   <= (pos == POS_PRE_TRL) ? S_TRL : S_PAD;
          end
        end
        S_PAD: begin
          crc <= crc_nxt;
          if (pos == POS_PRE_TRL) st <= S_TRL;
        end
        default: begin
          if (!tidx[2]) crc <= crc_nxt;
          tidx <= tidx + 1'b1;
          if (tidx == 3'd7) st <= S_PAY;
        end
      endcase
    end
  end

  logic [CW-1:0] rcnt, rtot, rpad;
  logic [39:0]   rsh;
  logic [47:0]   rsh_n;
  logic [31:0]   rcrc, rcrc_n;
  logic [LW-1:0] rlen;

  assign rtot   = (rx_sop ? '0 : rcnt) + 1'b1;
  assign rsh_n  = rx_sop ? {40'b0, rx_data} : {rsh, rx_data};
  assign rcrc_n = crc_step(rx_sop ? 32'hFFFFFFFF : rcrc, rx_data);
  assign rlen   = rsh_n[47:32];
  assign rpad   = ((CW'(rlen) + CW'(CELL + 7)) / CW'(CELL)) * CW'(CELL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt       <= '0;
      rsh        <= '0;
      rcrc       <= '1;
      rx_done    <= 1'b0;
      rx_len     <= '0;
      rx_bad_len <= 1'b0;
      rx_bad_crc <= 1'b0;
    end else begin
      rx_done <= rx_valid & rx_eop;
      if (rx_valid) begin
        rcnt <= rtot;
        rsh  <= rsh_n[39:0];
        rcrc <= rcrc_n;
        if (rx_eop) begin
          rx_len     <= rlen;
          rx_bad_len <= (rtot != rpad);
          rx_bad_crc <= (rcrc_n != RESIDUE);
        end
      end
    end
  end
endmodule

// File: rtl/aal5_frame_unit_chk.sv
module aal5_frame_unit_chk #(
  parameter int PW = 6,
  parameter int CELL = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_in_ready,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic [7:0]    tx_out_data,
  input logic          tx_out_sop,
  input logic          tx_out_eop,
  input logic          rx_valid,
  input logic          rx_eop,
  input logic          rx_done,
  input logic [1:0]    st,
  input logic [PW-1:0] pos
);
  p_sop_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && tx_out_ready && tx_out_sop) |-> (pos == '0));

  p_eop_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && tx_out_ready && tx_out_eop) |-> (pos == PW'(CELL - 1)));

  p_tail_blocks_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd0) |-> !tx_in_ready);

  p_done_after_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(rx_valid && rx_eop));

  p_hold_stalled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_data)));
endmodule

bind aal5_frame_unit aal5_frame_unit_chk #(.PW(PW), .CELL(CELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_in_ready(tx_in_ready),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .tx_out_data(tx_out_data), .tx_out_sop(tx_out_sop), .tx_out_eop(tx_out_eop),
  .rx_valid(rx_valid), .rx_eop(rx_eop), .rx_done(rx_done),
  .st(st), .pos(pos)
);

// File: tb/aal5_frame_unit_bench.sv
`timescale 1ns/1ps
module aal5_frame_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_in_valid = 0, tx_in_sop = 0, tx_in_eop = 0, tx_out_ready = 0;
  logic [7:0] tx_in_data = 0, tx_uu = 0, tx_cpi = 0;
  logic tx_in_ready, tx_out_valid, tx_out_sop, tx_out_eop;
  logic [7:0] tx_out_data;
  logic rx_valid = 0, rx_sop = 0, rx_eop = 0;
  logic [7:0] rx_data = 0;
  logic rx_done, rx_bad_len, rx_bad_crc;
  logic [15:0] rx_len;

  always #5 clk = ~clk;

  aal5_frame_unit u_aal5_frame_unit (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_in_sop(tx_in_sop), .tx_in_eop(tx_in_eop), .tx_uu(tx_uu), .tx_cpi(tx_cpi),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .tx_out_sop(tx_out_sop), .tx_out_eop(tx_out_eop),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_done(rx_done), .rx_len(rx_len), .rx_bad_len(rx_bad_len), .rx_bad_crc(rx_bad_crc)
  );

  // n[39:24] uu[23:16] cpi[15:8] seed[7:0]
  localparam logic [39:0] VEC [0:5] = '{
    {16'd1,   8'hA5, 8'h00, 8'h11},
    {16'd40,  8'h3C, 8'h01, 8'h22},
    {16'd41,  8'h00, 8'hFF, 8'h33},
    {16'd87,  8'h7E, 8'h10, 8'h44},
    {16'd88,  8'hC3, 8'h5A, 8'h55},
    {16'd100, 8'h01, 8'h02, 8'h66}
  };

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_b [0:255];
  logic [7:0] got_b [0:255];
  logic       got_s [0:255];
  logic       got_e [0:255];
  int exp_sz, got_sz;
  bit r7_bad, r11_bad;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 7; i >= 0; i--)
      r = (r[31] ^ d[i]) ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] pay(input int i, input logic [7:0] seed);
    return 8'(seed + i * 13);
  endfunction

  task automatic build(input int n, input logic [7:0] uu, input logic [7:0] cpi,
                       input logic [7:0] seed, input logic [15:0] lf);
    logic [31:0] c;
    exp_sz = ((n + 8 + 47) / 48) * 48;
    for (int i = 0; i < exp_sz; i++) exp_b[i] = 8'h00;
    for (int i = 0; i < n; i++) exp_b[i] = pay(i, seed);
    exp_b[exp_sz-8] = uu;
    exp_b[exp_sz-7] = cpi;
    exp_b[exp_sz-6] = lf[15:8];
    exp_b[exp_sz-5] = lf[7:0];
    c = 32'hFFFFFFFF;
    for (int i = 0; i < exp_sz - 4; i++) c = crc_b(c, exp_b[i]);
    c = ~c;
    exp_b[exp_sz-4] = c[31:24];
    exp_b[exp_sz-3] = c[23:16];
    exp_b[exp_sz-2] = c[15:8];
    exp_b[exp_sz-1] = c[7:0];
  endtask

  task automatic run_tx(input int n, input logic [7:0] uu, input logic [7:0] cpi,
                        input logic [7:0] seed);
    int idx = 0, cyc = 0;
    bit done = 0, prev_stall = 0;
    logic [7:0] prev_d = 0;
    got_sz = 0; r7_bad = 0; r11_bad = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      tx_out_ready = ((cyc % 5) != 3);
      tx_in_valid  = (idx < n);
      tx_in_data   = pay(idx, seed);
      tx_in_sop    = (idx == 0);
      tx_in_eop    = (idx == n - 1);
      tx_uu = uu; tx_cpi = cpi;
      #1;
      if (prev_stall && (!tx_out_valid || tx_out_data != prev_d)) r11_bad = 1;
      prev_stall = tx_out_valid && !tx_out_ready;
      prev_d = tx_out_data;
      if (tx_out_valid && tx_out_ready) begin
        if (got_sz >= n && tx_in_ready) r7_bad = 1;
        got_b[got_sz] = tx_out_data;
        got_s[got_sz] = tx_out_sop;
        got_e[got_sz] = tx_out_eop;
        got_sz++;
        if (tx_out_eop) done = 1;
      end
      if (tx_in_valid && tx_in_ready) idx++;
      cyc++;
    end
    @(negedge clk);
    tx_in_valid = 0; tx_in_sop = 0; tx_in_eop = 0; tx_out_ready = 0;
  endtask

  task automatic send_rx(input int cnt, input bit from_got);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      rx_valid = 1;
      rx_data  = from_got ? got_b[i] : exp_b[i];
      rx_sop   = (i == 0);
      rx_eop   = (i == cnt - 1);
    end
    @(negedge clk);
    rx_valid = 0; rx_sop = 0; rx_eop = 0;
    #1;
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(!tx_out_valid, "R1", "tx_out_valid after reset", tx_out_valid, 0);
    check(!rx_done, "R1", "rx_done after reset", rx_done, 0);

    for (int v = 0; v < 6; v++) begin
      int n;
      bit s_ok, e_ok, p_ok, z_ok, t_ok, c_ok;
      n = int'(VEC[v][39:24]);
      build(n, VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 16'(n));
      run_tx(n, VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
      check(got_sz == exp_sz, "R3", "PDU size", got_sz, exp_sz);
      s_ok = 1; e_ok = 1; p_ok = 1; z_ok = 1; t_ok = 1; c_ok = 1;
      for (int i = 0; i < got_sz && i < exp_sz; i++) begin
        if (got_s[i] != (i == 0)) s_ok = 0;
        if (got_e[i] != (i == exp_sz - 1)) e_ok = 0;
        if (got_b[i] != exp_b[i]) begin
          if (i < n) p_ok = 0;
          else if (i < exp_sz - 8) z_ok = 0;
          else if (i < exp_sz - 4) t_ok = 0;
          else c_ok = 0;
        end
      end
      check(s_ok && p_ok, "R2", "payload/sop", v, n);
      check(e_ok, "R3", "eop placement", v, exp_sz);
      check(z_ok && (exp_sz - n - 8) <= 47, "R4", "pad zero", v, exp_sz - n - 8);
      check(t_ok, "R5", "trailer word", {got_b[exp_sz-8], got_b[exp_sz-7], got_b[exp_sz-6], got_b[exp_sz-5]},
            {exp_b[exp_sz-8], exp_b[exp_sz-7], exp_b[exp_sz-6], exp_b[exp_sz-5]});
      check(c_ok, "R6", "crc", {got_b[exp_sz-4], got_b[exp_sz-3], got_b[exp_sz-2], got_b[exp_sz-1]},
            {exp_b[exp_sz-4], exp_b[exp_sz-3], exp_b[exp_sz-2], exp_b[exp_sz-1]});
      check(!r7_bad, "R7", "input ready in tail", r7_bad, 0);
      check(!r11_bad, "R11", "hold under stall", r11_bad, 0);
      send_rx(got_sz, 1);
      check(rx_done && rx_len == 16'(n), "R8", "rx length", rx_len, n);
      check(!rx_bad_len, "R9", "bad_len on good PDU", rx_bad_len, 0);
      check(!rx_bad_crc, "R10", "bad_crc on good PDU", rx_bad_crc, 0);
    end

    // corrupt one payload byte: CRC error only
    build(30, 8'h12, 8'h34, 8'h77, 16'd30);
    exp_b[5] = exp_b[5] ^ 8'h40;
    send_rx(exp_sz, 0);
    check(rx_bad_crc, "R10", "corrupted payload crc", rx_bad_crc, 1);
    check(!rx_bad_len, "R9", "corrupted payload len", rx_bad_len, 0);

    // length field inconsistent with cell count, CRC valid
    build(30, 8'h12, 8'h34, 8'h77, 16'd60);
    send_rx(exp_sz, 0);
    check(rx_done && rx_len == 16'd60, "R8", "inconsistent rx_len", rx_len, 60);
    check(rx_bad_len, "R9", "length mismatch", rx_bad_len, 1);
    check(!rx_bad_crc, "R10", "crc ok on length mismatch", rx_bad_crc, 0);

    // length 40 claims one cell; 96 bytes received
    build(50, 8'h00, 8'h00, 8'h01, 16'd40);
    send_rx(exp_sz, 0);
    check(rx_bad_len, "R9", "two cells for one-cell length", rx_bad_len, 1);

    // unaligned frame length (47 bytes)
    build(30, 8'h00, 8'h00, 8'h02, 16'd30);
    send_rx(47, 0);
    check(rx_bad_len, "R9", "unaligned byte count", rx_bad_len, 1);

    @(negedge clk); #1;
    check(!rx_done, "R8", "rx_done single pulse", rx_done, 0);
    finish_run();
  end
endmodule